// File: doc/BRIEF.md
# Word FIFO with DMA Request/Acknowledge Handshake

This block carries 16-bit words from a host processor to a DMA channel inside a single clock domain. The host polls a full flag and writes a word through a data port only while that flag is low. A write that arrives while the FIFO is full is dropped, and a sticky overflow flag records it until the host clears it.

The consumer side has no valid/ready pop port. The FIFO requests service on a request line and produces one rising edge for each word it holds. The DMA channel answers with an active-high acknowledge. Each acknowledge given while the request is high removes the head word and drives it on the consumer data bus during that cycle. After each acknowledge the request line goes low for one cycle, so the next word makes a fresh rising edge for an edge-detecting controller. The DMA channel reads from one fixed address and writes to a destination address that increments. Storage is eight words deep, and the full and empty conditions come from read and write pointers that carry one extra wrap bit.

Top module: `word_fifo_dreq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `dma_req`, `host_full` and `host_ovf` are 0 and `dma_rdata` is 0.
- R2: A host write while `host_full` is 0 stores the word. `host_full` is 1 in the cycle after the edge that stores the eighth held word, and it drops after the next acknowledged pop.
- R3: A host write while `host_full` is 1 is discarded. The stored words and their order do not change, and the discarded word never reaches `dma_rdata`.
- R4: When the FIFO holds a word and `dma_req` is low with no acknowledge pending, `dma_req` goes high on the next clock edge. A word written into an empty FIFO raises `dma_req` two edges after the write is presented.
- R5: A cycle where `dma_ack` and `dma_req` are both 1 pops the head word and shows it on `dma_rdata` in that cycle. Words leave in the order they were written, and `dma_rdata` is 0 in every other cycle.
- R6: After an acknowledged pop, `dma_req` is low for exactly one cycle. It then rises again if any word remains.
- R7: `dma_ack` while `dma_req` is low pops nothing. `dma_rdata` stays 0 and no word is lost.
- R8: `host_ovf` is set by a discarded write and stays set until a `host_ovf_clr` pulse clears it. If a discarded write and a clear come in the same cycle, the set wins.
- R9: When the FIFO is empty, `dma_req` stays low.
- R10: A host write and an acknowledged pop in the same cycle, with the FIFO not full, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write word |
| host_full | output | 1 | All eight entries are occupied |
| host_ovf | output | 1 | Sticky flag for a dropped write |
| host_ovf_clr | input | 1 | Clears the overflow flag |
| dma_req | output | 1 | Service request, one rising edge per word |
| dma_ack | input | 1 | Active-high acknowledge from the DMA channel |
| dma_rdata | output | 16 | Popped word, valid in the acknowledged cycle |

## Verification
A wrong pointer or wrap bit shows up at the ports when the next acknowledge returns a word out of order, or when `host_full` comes too early or too late. Either error appears within eight writes of the fault. If the request register skips its low cycle, `dma_req` stays high across back-to-back words, which is visible one cycle after an acknowledge. A lost overflow set shows on the cycle after a dropped write, and a missing set-over-clear priority shows on the cycle after a write and a clear arrive together.

// File: rtl/word_fifo_dreq.sv
module word_fifo_dreq #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [WIDTH-1:0] host_wdata,
  output logic             host_full,
  output logic             host_ovf,
  input  logic             host_ovf_clr,
  output logic             dma_req,
  input  logic             dma_ack,
  output logic [WIDTH-1:0] dma_rdata
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wptr, rptr, cnt;
  logic             req_q, ovf_q, push, pop, drop;

  assign cnt       = wptr - rptr;
  assign host_full = (cnt == (AW+1)'(DEPTH));
  assign push      = host_we && !host_full;
  assign drop      = host_we && host_full;
  assign pop       = dma_ack && req_q;
  assign dma_req   = req_q;
  assign host_ovf  = ovf_q;
  assign dma_rdata = pop ? mem[rptr[AW-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (push) mem[wptr[AW-1:0]] <= host_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      req_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      req_q <= req_q ? !dma_ack : (cnt != '0);
      if (drop)              ovf_q <= 1'b1;
      else if (host_ovf_clr) ovf_q <= 1'b0;
    end
  end
endmodule

// File: rtl/word_fifo_dreq_chk.sv
module word_fifo_dreq_chk #(
  parameter int AW = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_we,
  input logic        host_full,
  input logic        host_ovf,
  input logic        dma_req,
  input logic        dma_ack,
  input logic [15:0] dma_rdata,
  input logic [AW:0] cnt
);
  AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && dma_ack |=> !dma_req); // R6
  AST_NO_REQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> cnt != '0); // R9
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    host_we && host_full && !(dma_req && dma_ack) |=> $stable(cnt)); // R3
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    host_we && host_full |=> host_ovf); // R8
  AST_PUSH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    host_we && !host_full && !(dma_req && dma_ack) |=> cnt == $past(cnt) + 1'b1); // R2
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_req && dma_ack) |-> dma_rdata == '0); // R5
endmodule

bind word_fifo_dreq word_fifo_dreq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_full(host_full),
  .host_ovf(host_ovf), .dma_req(dma_req), .dma_ack(dma_ack),
  .dma_rdata(dma_rdata), .cnt(cnt)
);

// File: tb/word_fifo_dreq_tb.sv
`timescale 1ns/1ps
module word_fifo_dreq_tb;
  logic        clk = 0, rst_n = 0, host_we = 0, host_ovf_clr = 0, dma_ack = 0;
  logic [15:0] host_wdata = '0;
  logic        host_full, host_ovf, dma_req;
  logic [15:0] dma_rdata;
  int checks = 0, errors = 0;
  logic [15:0] q[$];
  bit ovf_m = 0;

  always #4 clk = ~clk;

  word_fifo_dreq u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] w);
    @(negedge clk);
    host_we = 1; host_wdata = w;
    if (q.size() < 8) q.push_back(w); else ovf_m = 1;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic wait_req();
    for (int i = 0; i < 20 && !dma_req; i++) @(negedge clk);
  endtask

  task automatic pop_one(input string req);
    wait_req();
    chk(dma_req == 1, req, dma_req, 1);
    dma_ack = 1;
    #1;
    chk(dma_rdata == q[0], req, dma_rdata, q[0]);
    void'(q.pop_front());
    @(negedge clk);
    dma_ack = 0;
    chk(dma_req == 0, "R6 gap", dma_req, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(dma_req == 0 && host_full == 0 && host_ovf == 0 && dma_rdata == 0, "R1 in reset", dma_req, 0);
    rst_n = 1;
    @(negedge clk);
    chk(dma_req == 0 && host_full == 0 && host_ovf == 0, "R1 after reset", {host_full, host_ovf}, 0);
  endtask

  task automatic t_latency();
    push(16'h1111);
    chk(dma_req == 0, "R4 not yet", dma_req, 0);
    @(negedge clk);
    chk(dma_req == 1, "R4 raised", dma_req, 1);
    pop_one("R5 single");
    repeat (3) @(negedge clk);
    chk(dma_req == 0, "R9 empty idle", dma_req, 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 8; i++) push(16'hA000 + 16'(i));
    chk(host_full == 1, "R2 full", host_full, 1);
    chk(host_ovf == 0, "R8 no ovf yet", host_ovf, 0);
    push(16'hDEAD);
    chk(host_ovf == 1, "R8 ovf set", host_ovf, 1);
    chk(host_full == 1, "R3 still full", host_full, 1);
    pop_one("R5 order 0");
    chk(host_full == 0, "R2 full drops", host_full, 0);
    @(negedge clk);
    chk(dma_req == 1, "R6 re-rise", dma_req, 1);
    while (q.size() > 0) pop_one("R3 order");
    repeat (3) @(negedge clk);
    chk(dma_req == 0 && dma_rdata == 0, "R9 drained", dma_req, 0);
  endtask

  task automatic t_ovf_clear();
    chk(host_ovf == 1, "R8 sticky", host_ovf, 1);
    @(negedge clk); host_ovf_clr = 1;
    @(negedge clk); host_ovf_clr = 0;
    chk(host_ovf == 0, "R8 cleared", host_ovf, 0);
    for (int i = 0; i < 8; i++) push(16'hB000 + 16'(i));
    @(negedge clk);
    host_we = 1; host_wdata = 16'hBEEF; host_ovf_clr = 1;
    @(negedge clk);
    host_we = 0; host_ovf_clr = 0;
    chk(host_ovf == 1, "R8 set wins", host_ovf, 1);
    while (q.size() > 0) pop_one("R3 order after drop");
    @(negedge clk); host_ovf_clr = 1;
    @(negedge clk); host_ovf_clr = 0;
  endtask

  task automatic t_stray_ack();
    @(negedge clk);
    dma_ack = 1;
    repeat (3) begin
      @(negedge clk); #1;
      chk(dma_rdata == 0 && dma_req == 0, "R7 ack when empty", dma_rdata, 0);
    end
    dma_ack = 0;
    push(16'h2222);
    push(16'h3333);
    wait_req();
    dma_ack = 1; #1;
    chk(dma_rdata == 16'h2222, "R5 first", dma_rdata, 16'h2222);
    void'(q.pop_front());
    @(negedge clk); #1;
    chk(dma_req == 0 && dma_rdata == 0, "R7 ack in gap", dma_rdata, 0);
    dma_ack = 0;
    @(negedge clk);
    pop_one("R7 word kept");
  endtask

  task automatic t_both();
    push(16'h4444);
    wait_req();
    host_we = 1; host_wdata = 16'h5555; dma_ack = 1; q.push_back(16'h5555);
    #1;
    chk(dma_rdata == 16'h4444, "R10 pop", dma_rdata, 16'h4444);
    void'(q.pop_front());
    @(negedge clk);
    host_we = 0; dma_ack = 0;
    pop_one("R10 push kept");
    repeat (3) @(negedge clk);
    chk(dma_req == 0, "R10 empty after", dma_req, 0);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_fill();
    t_ovf_clear();
    t_stray_ack();
    t_both();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule